// File: doc/BRIEF.md
# Self-Timed Byte-Wide Flash Programming Controller

This block is the device-side logic for parallel programming of a small on-chip code store. A programmer supplies an address, a data byte, a two-bit operation code, two signature-select lines, an active-low program strobe and a program-enable level. A single strobe pulse in write mode launches a byte write that finishes on its own after a fixed number of clock cycles. A chip erase needs the strobe held low for a longer fixed period. Progress shows on an active-low busy output. It also shows through data polling: while a write runs, reading the byte being written returns bit 7 inverted.

The store is a behavioural register array that comes up fully erased (all bytes FFh). A write can only clear bits, so a byte that is not blank needs a chip erase before it can take new data. Two lock bits block verify reads once either one is programmed. Only a chip erase clears them. Read mode with both signature-select lines low returns fixed identification bytes instead of array data. Commands that arrive while an operation runs are dropped, and they set a sticky error flag.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, and after a completed chip erase, every array location reads FFh in verify mode.
- R2: With `progEn` high and `opMode`=01 (write), one falling edge of `progStrobeN` starts a byte write. The write completes after exactly `WRITE_CYCLES` clock cycles with no further strobe.
- R3: During a write, a verify read of the address being written returns the written byte with bit 7 inverted. Once the write completes, the read returns the byte unchanged.
- R4: `readyBusy` goes low on the cycle after an accepted strobe edge. It stays low while a write, lock-program or erase operation is running, and it is high otherwise.
- R5: With `opMode`=10 (erase), the strobe must stay low for `ERASE_HOLD` cycles. An erase then sets every byte to FFh and clears both lock bits. Releasing the strobe earlier aborts the erase and changes nothing.
- R6: A write stores the bitwise AND of the old contents and the new data byte.
- R7: A read with `opMode`=00 and `sigSel`=00 returns 1Eh at address 30h and 51h at address 31h. At address 32h it returns FFh when `HIGH_VOLT`=1 and 05h when `HIGH_VOLT`=0. Every other address returns FFh.
- R8: A read with `opMode`=00 and `sigSel` not 00 returns the array contents while neither lock bit is set. `opMode`=11 (lock program) sets the lock bit selected by `addrIn[0]` after `WRITE_CYCLES` cycles. After that, every verify read returns FFh, and signature reads are not affected.
- R9: A write, erase or lock strobe that arrives while busy is ignored and sets `errFlag`. The flag stays set until reset.
- R10: While `progEn` is low, a strobe starts no operation and changes no contents.
- R11: `dataOut` is registered and shows the read result one clock after the address is applied. It reads FFh whenever `opMode` is not 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opMode | input | 2 | 00 read, 01 byte write, 10 chip erase, 11 lock program |
| sigSel | input | 2 | 00 selects signature read in read mode |
| addrIn | input | ADDR_W | Byte address |
| dataIn | input | 8 | Write data |
| progStrobeN | input | 1 | Active-low program strobe |
| progEn | input | 1 | Program enable level |
| dataOut | output | 8 | Registered read data |
| readyBusy | output | 1 | High = ready, low = busy |
| errFlag | output | 1 | Sticky busy-collision flag |

## Verification
The assertions assume that every input is synchronous to `clk` and changes only between rising edges. They assume a strobe low phase lasts at least one cycle, so that a falling edge is always seen by one rising edge. The bench drives every input on the falling clock edge and holds each strobe level for whole cycles. It issues extra strobes during a busy period on purpose, only to exercise the collision flag.

// File: rtl/fp_pkg.sv
package fp_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_ERASE = 2'b10,
    OP_LOCK  = 2'b11
  } opMode_e;

  typedef struct packed {
    logic latchReq;
    logic commitWrite;
    logic commitLock;
    logic eraseAll;
    logic pollOn;
  } dpCtrl_t;

  localparam logic [7:0] SIG_BYTE0 = 8'h1E;
  localparam logic [7:0] SIG_BYTE1 = 8'h51;
  localparam logic [7:0] SIG_HV    = 8'hFF;
  localparam logic [7:0] SIG_LV    = 8'h05;
  localparam logic [7:0] BLANK     = 8'hFF;
endpackage

// File: rtl/flash_prog_ctl.sv
module flash_prog_ctl
  import fp_pkg::*;
#(
  parameter int WRITE_CYCLES = 20,
  parameter int ERASE_HOLD   = 40
) (
  input  logic    clk,
  input  logic    rstN,
  input  opMode_e opMode,
  input  logic    strobeN,
  input  logic    progEn,
  output dpCtrl_t ctrl,
  output logic    busy,
  output logic    errFlag
);
  localparam int MAX_CNT = (WRITE_CYCLES > ERASE_HOLD) ? WRITE_CYCLES : ERASE_HOLD;
  localparam int CW      = $clog2(MAX_CNT + 1);
  localparam logic [CW-1:0] WR_LAST = CW'(WRITE_CYCLES - 1);
  localparam logic [CW-1:0] ER_LAST = CW'(ERASE_HOLD - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WRITE, S_LOCK, S_ERASE, S_ERASE_WAIT
  } state_e;

  state_e        state, stateNxt;
  logic [CW-1:0] cnt, cntNxt;
  logic          prevStrobe;
  logic          strobeFall;
  logic          cmdStrobe;
  logic          errNxt;

  assign strobeFall = prevStrobe & ~strobeN;
  assign cmdStrobe  = strobeFall & progEn & (opMode != OP_READ);

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    errNxt   = errFlag;
    ctrl     = '0;
    unique case (state)
      S_IDLE: begin
        cntNxt = '0;
        if (cmdStrobe) begin
          unique case (opMode)
            OP_WRITE: begin
              stateNxt      = S_WRITE;
              ctrl.latchReq = 1'b1;
            end
            OP_LOCK: begin
              stateNxt      = S_LOCK;
              ctrl.latchReq = 1'b1;
            end
            OP_ERASE: stateNxt = S_ERASE;
            default:  stateNxt = S_IDLE;
          endcase
        end
      end
      S_WRITE: begin
        ctrl.pollOn = 1'b1;
        if (cmdStrobe) errNxt = 1'b1;
        if (cnt == WR_LAST) begin
          ctrl.commitWrite = 1'b1;
          stateNxt         = S_IDLE;
          cntNxt           = '0;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      S_LOCK: begin
        if (cmdStrobe) errNxt = 1'b1;
        if (cnt == WR_LAST) begin
          ctrl.commitLock = 1'b1;
          stateNxt        = S_IDLE;
          cntNxt          = '0;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      S_ERASE: begin
        if (strobeN) begin
          stateNxt = S_IDLE;
          cntNxt   = '0;
        end else if (cnt == ER_LAST) begin
          ctrl.eraseAll = 1'b1;
          stateNxt      = S_ERASE_WAIT;
          cntNxt        = '0;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      S_ERASE_WAIT: begin
        if (strobeN) stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      cnt        <= '0;
      prevStrobe <= 1'b1;
      errFlag    <= 1'b0;
    end else begin
      state      <= stateNxt;
      cnt        <= cntNxt;
      prevStrobe <= strobeN;
      errFlag    <= errNxt;
    end
  end

  assign busy = (state == S_WRITE) || (state == S_LOCK) || (state == S_ERASE);
endmodule

// File: rtl/flash_prog_dp.sv
module flash_prog_dp
  import fp_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter bit HIGH_VOLT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  opMode_e           opMode,
  input  logic [1:0]        sigSel,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] SIG_A0 = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] SIG_A1 = ADDR_W'(8'h31);
  localparam logic [ADDR_W-1:0] SIG_A2 = ADDR_W'(8'h32);
  localparam logic [7:0] SIG_MODE = HIGH_VOLT ? SIG_HV : SIG_LV;

  logic [7:0]        mem [DEPTH];
  logic [1:0]        lockBits;
  logic [ADDR_W-1:0] wAddr;
  logic [7:0]        wData;
  logic [7:0]        rdNxt;
  logic [7:0]        sigByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK;
      lockBits <= '0;
      wAddr    <= '0;
      wData    <= BLANK;
    end else begin
      if (ctrl.latchReq) begin
        wAddr <= addrIn;
        wData <= dataIn;
      end
      if (ctrl.eraseAll) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK;
        lockBits <= '0;
      end else begin
        if (ctrl.commitWrite) mem[wAddr] <= mem[wAddr] & wData;
        if (ctrl.commitLock)  lockBits[wAddr[0]] <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (addrIn)
      SIG_A0:  sigByte = SIG_BYTE0;
      SIG_A1:  sigByte = SIG_BYTE1;
      SIG_A2:  sigByte = SIG_MODE;
      default: sigByte = BLANK;
    endcase
  end

  always_comb begin
    if (opMode != OP_READ)               rdNxt = BLANK;
    else if (sigSel == 2'b00)            rdNxt = sigByte;
    else if (|lockBits)                  rdNxt = BLANK;
    else if (ctrl.pollOn && addrIn == wAddr) rdNxt = {~wData[7], wData[6:0]};
    else                                 rdNxt = mem[addrIn];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataOut <= BLANK;
    else       dataOut <= rdNxt;
  end
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import fp_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int WRITE_CYCLES = 20,
  parameter int ERASE_HOLD   = 40,
  parameter bit HIGH_VOLT    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        opMode,
  input  logic [1:0]        sigSel,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  input  logic              progStrobeN,
  input  logic              progEn,
  output logic [7:0]        dataOut,
  output logic              readyBusy,
  output logic              errFlag
);
  dpCtrl_t ctrl;
  opMode_e opModeE;
  logic    busy;

  assign opModeE   = opMode_e'(opMode);
  assign readyBusy = ~busy;

  flash_prog_ctl #(
    .WRITE_CYCLES(WRITE_CYCLES),
    .ERASE_HOLD  (ERASE_HOLD)
  ) uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .opMode (opModeE),
    .strobeN(progStrobeN),
    .progEn (progEn),
    .ctrl   (ctrl),
    .busy   (busy),
    .errFlag(errFlag)
  );

  flash_prog_dp #(
    .ADDR_W   (ADDR_W),
    .HIGH_VOLT(HIGH_VOLT)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .opMode (opModeE),
    .sigSel (sigSel),
    .addrIn (addrIn),
    .dataIn (dataIn),
    .dataOut(dataOut)
  );
endmodule

// File: rtl/flash_prog_chk.sv
module flash_prog_chk #(
  parameter int ADDR_W       = 6,
  parameter int WRITE_CYCLES = 20,
  parameter int ERASE_HOLD   = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        opMode,
  input logic [1:0]        sigSel,
  input logic [ADDR_W-1:0] addrIn,
  input logic              progStrobeN,
  input logic              progEn,
  input logic [7:0]        dataOut,
  input logic              readyBusy,
  input logic              errFlag
);
  localparam int MAX_RUN = (WRITE_CYCLES > ERASE_HOLD) ? WRITE_CYCLES : ERASE_HOLD;
  localparam int RW = $clog2(MAX_RUN + 2);

  logic [RW-1:0] busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busyRun <= '0;
    else if (readyBusy) busyRun <= '0;
    else if (busyRun != {RW{1'b1}}) busyRun <= busyRun + 1'b1;
  end

  // R2
  busy_bounded_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(busyRun) <= MAX_RUN);

  // R4
  start_on_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyBusy) |-> (!$past(progStrobeN) && $past(progStrobeN, 2) && $past(progEn)));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R10
  no_enable_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readyBusy && !progEn) |=> readyBusy);

  // R11
  nonread_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opMode != 2'b00) |=> (dataOut == 8'hFF));

  // R7
  sig_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == 2'b00 && sigSel == 2'b00 && addrIn == ADDR_W'(8'h30)) |=> (dataOut == 8'h1E));
endmodule

bind flash_prog_ctrl flash_prog_chk #(
  .ADDR_W      (ADDR_W),
  .WRITE_CYCLES(WRITE_CYCLES),
  .ERASE_HOLD  (ERASE_HOLD)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .opMode     (opMode),
  .sigSel     (sigSel),
  .addrIn     (addrIn),
  .progStrobeN(progStrobeN),
  .progEn     (progEn),
  .dataOut    (dataOut),
  .readyBusy  (readyBusy),
  .errFlag    (errFlag)
);

// File: tb/tb_flash_prog_ctrl.sv
module tb_flash_prog_ctrl;
  localparam int AW = 6;
  localparam int WC = 20;
  localparam int EH = 40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    opMode = 2'b00;
  logic [1:0]    sigSel = 2'b11;
  logic [AW-1:0] addrIn = '0;
  logic [7:0]    dataIn = '0;
  logic          progStrobeN = 1'b1;
  logic          progEn = 1'b0;
  logic [7:0]    dataOut;
  logic          readyBusy;
  logic          errFlag;

  always #2.5 clk = ~clk;

  flash_prog_ctrl #(
    .ADDR_W(AW), .WRITE_CYCLES(WC), .ERASE_HOLD(EH), .HIGH_VOLT(1'b0)
  ) dut (
    .clk(clk), .rstN(rstN), .opMode(opMode), .sigSel(sigSel), .addrIn(addrIn),
    .dataIn(dataIn), .progStrobeN(progStrobeN), .progEn(progEn),
    .dataOut(dataOut), .readyBusy(readyBusy), .errFlag(errFlag)
  );

  typedef struct {
    int         due;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    nChecks = 0;
  int    nFails = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      check(dataOut === it.exp, it.tag, dataOut, it.exp);
    end
  end

  task automatic readExp(input logic [AW-1:0] a, input logic [1:0] sel,
                         input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    opMode = 2'b00; sigSel = sel; addrIn = a;
    it.due = cyc + 1; it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic waitReady(output int n);
    n = 0;
    while (!readyBusy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // one strobe pulse; returns at the negedge after release
  task automatic pulse(input logic [1:0] m, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    opMode = m; addrIn = a; dataIn = d; progStrobeN = 1'b0;
    @(negedge clk);
    progStrobeN = 1'b1;
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [7:0] d);
    int n;
    pulse(2'b01, a, d);
    waitReady(n);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int n;
    item_t it;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    progEn = 1'b1;
    @(negedge clk);
    check(readyBusy === 1'b1, "R4 reset ready", readyBusy, 1);
    check(errFlag === 1'b0, "R9 reset err", errFlag, 0);
    readExp(6'd5, 2'b11, 8'hFF, "R1 reset blank 5");
    readExp(6'd63, 2'b11, 8'hFF, "R1 reset blank 63");

    // R2/R3/R4: write with polling
    pulse(2'b01, 6'd5, 8'hA5);
    check(readyBusy === 1'b0, "R4 busy after strobe", readyBusy, 0);
    opMode = 2'b00; sigSel = 2'b11; addrIn = 6'd5;
    it.due = cyc + 1; it.exp = 8'h25; it.tag = "R3 poll inverted bit7";
    q.push_back(it);
    waitReady(n);
    check(n == WC, "R2 write duration", n, WC);
    readExp(6'd5, 2'b11, 8'hA5, "R3 true data after write");

    // R6: AND behaviour
    doWrite(6'd5, 8'h0F);
    readExp(6'd5, 2'b11, 8'h05, "R6 write clears only");
    doWrite(6'd6, 8'h3C);
    readExp(6'd6, 2'b11, 8'h3C, "R8 verify returns array");

    // R9: collision
    pulse(2'b01, 6'd7, 8'h00);
    repeat (3) @(negedge clk);
    pulse(2'b01, 6'd8, 8'h00);
    @(negedge clk);
    check(errFlag === 1'b1, "R9 err set on collision", errFlag, 1);
    waitReady(n);
    readExp(6'd7, 2'b11, 8'h00, "R9 first write kept");
    readExp(6'd8, 2'b11, 8'hFF, "R9 second write ignored");

    // R10: program enable low
    progEn = 1'b0;
    pulse(2'b01, 6'd9, 8'h00);
    check(readyBusy === 1'b1, "R10 no start without enable", readyBusy, 1);
    progEn = 1'b1;
    readExp(6'd9, 2'b11, 8'hFF, "R10 no change");

    // R7: signature
    readExp(6'h30, 2'b00, 8'h1E, "R7 sig 30");
    readExp(6'h31, 2'b00, 8'h51, "R7 sig 31");
    readExp(6'h32, 2'b00, 8'h05, "R7 sig 32 low voltage");
    readExp(6'h33, 2'b00, 8'hFF, "R7 sig other");

    // R11: non-read mode output
    @(negedge clk);
    opMode = 2'b01; addrIn = 6'd6;
    it.due = cyc + 1; it.exp = 8'hFF; it.tag = "R11 non-read blank";
    q.push_back(it);
    @(negedge clk);
    opMode = 2'b00;

    // R5: aborted erase
    @(negedge clk);
    opMode = 2'b10; progStrobeN = 1'b0;
    repeat (EH / 2) @(negedge clk);
    check(readyBusy === 1'b0, "R4 busy during erase", readyBusy, 0);
    progStrobeN = 1'b1;
    @(negedge clk);
    check(readyBusy === 1'b1, "R5 abort returns ready", readyBusy, 1);
    readExp(6'd5, 2'b11, 8'h05, "R5 abort keeps data");

    // R8: lock bit
    pulse(2'b11, 6'd1, 8'h00);
    waitReady(n);
    check(n == WC, "R8 lock duration", n, WC);
    readExp(6'd5, 2'b11, 8'hFF, "R8 locked verify 5");
    readExp(6'd6, 2'b11, 8'hFF, "R8 locked verify 6");
    readExp(6'h31, 2'b00, 8'h51, "R8 signature unaffected");

    // R5/R1: full erase
    @(negedge clk);
    opMode = 2'b10; progStrobeN = 1'b0;
    repeat (EH + 1) @(negedge clk);
    check(readyBusy === 1'b1, "R5 erase complete ready", readyBusy, 1);
    progStrobeN = 1'b1;
    @(negedge clk);
    readExp(6'd6, 2'b11, 8'hFF, "R1 erased 6");
    readExp(6'd7, 2'b11, 8'hFF, "R5 erased 7");
    doWrite(6'd5, 8'h12);
    readExp(6'd5, 2'b11, 8'h12, "R5 locks cleared and rewrite");
    check(errFlag === 1'b1, "R9 err sticky", errFlag, 1);

    repeat (3) @(negedge clk);
    check(q.size() == 0, "scoreboard drained", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule